// File: doc/BRIEF.md
# Dual-Field Polynomial Hash Engine

This unit computes the universal hash used by the two common counter-mode AEAD constructions. It folds a sequence of 128-bit blocks into an accumulator in GF(2^128) under a 128-bit hash key. A one-bit field selector picks one of two conventions:

- The big-endian, bit-reflected field reduced by x^128 + x^7 + x^2 + x + 1.
- The little-endian field reduced by x^128 + x^127 + x^126 + x^121 + 1, whose product carries an extra factor of x^-128.

A caller pulses `start` with the key, the selector and the two bit lengths. It then streams already zero-padded data blocks under a valid/ready handshake and flags the final one. The unit appends the length block itself and presents the result with a one-cycle `done` strobe.

Both fields run on one bit-serial GF(2^128) multiplier. The little-endian field is reached through byte reversal of the operands and the result, and a single multiplication of the key by x when the key is loaded. Every multiply takes exactly 128 cycles whatever the data or key, and no table is indexed by secret values.

Top module: `ghpv_hash`

## Requirements
- R1: After reset `blk_ready` and `done` are low and `hash` is all zeros.
- R2: With `mode` = 0 the result is Y_i = (Y_{i-1} xor X_i)·H in the field reduced by x^128+x^7+x^2+x+1, starting from Y_0 = 0. The most significant bit of a 128-bit bus value (byte 0 at bits 127:120) is the x^0 coefficient. The final X is the length block {aad_bits, msg_bits}, each as a 64-bit big-endian value, and `hash` is Y in the same bus layout.
- R3: With `mode` = 1 each bus value is read as a little-endian 16-byte integer whose bit k is the x^k coefficient. The step is Y_i = (Y_{i-1} xor X_i)·H·x^-128 modulo x^128+x^127+x^126+x^121+1. The length block holds `aad_bits` as a 64-bit little-endian value in bytes 0..7 and `msg_bits` likewise in bytes 8..15. `hash` is returned in the same byte layout.
- R4: After a non-final data block is accepted (`blk_valid` and `blk_ready` high at a clock edge), `blk_ready` stays low for exactly 128 cycles and then rises again, for every key and data value.
- R5: After the final data block is accepted, `done` rises in the 257th cycle, for one cycle, and `hash` carries the new result from that cycle on. `blk_ready` stays low until the next start.
- R6: A start with both lengths zero takes no data. `blk_ready` never rises, `done` pulses 128 cycles after the start edge, and `hash` is zero.
- R7: The accumulator restarts from zero at each start, so identical hashes run back to back return identical results.
- R8: A `start` pulse while a hash is in progress is ignored and does not change that hash's result.
- R9: Exactly one block is consumed per ready window, so holding `blk_valid` high across multiplies does not duplicate or skip blocks.
- R10: `hash` changes only in a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a hash; sampled only when idle |
| mode | input | 1 | 0 = big-endian reflected field, 1 = little-endian field |
| key | input | 128 | Hash key, byte 0 in bits 127:120 |
| aad_bits | input | 64 | Associated-data length in bits |
| msg_bits | input | 64 | Message length in bits |
| blk_valid | input | 1 | Data block present |
| blk_data | input | 128 | Padded data block, byte 0 in bits 127:120 |
| blk_last | input | 1 | Marks the final data block |
| blk_ready | output | 1 | Unit can take a data block this cycle |
| hash | output | 128 | Result of the last completed hash |
| done | output | 1 | One-cycle strobe when `hash` is updated |

## Verification
A wrong bit in the accumulator, the shifted key or the reduction feedback reaches the ports only at the end of the hash. It then shows as a wrong `hash` value at the `done` strobe, up to 257 cycles after the final block. A fault in the step counter or the handshake control shows much sooner: the ready window after the first accepted block is no longer exactly 128 cycles long. Sweeping a walking-one key through both fields makes each key bit and each reduction tap decide the result on its own. A reference model computed arithmetically in the little-endian field, rather than through byte reversal, catches any mistake in the mapping between the two fields.

// File: rtl/ghpv_pkg.sv
package ghpv_pkg;

    localparam int BLK_W   = 128;
    localparam int LEN_W   = 64;
    localparam int BYTES   = BLK_W / 8;
    localparam int CNT_W   = $clog2(BLK_W);

    // Feedback constant of the reflected field x^128 + x^7 + x^2 + x + 1.
    localparam logic [BLK_W-1:0] REFL_FB = {8'hE1, {(BLK_W-8){1'b0}}};

    typedef enum logic {
        FLD_BE = 1'b0,
        FLD_LE = 1'b1
    } field_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAKE = 2'd1,
        ST_MUL  = 2'd2
    } state_e;

    typedef struct packed {
        field_e            fld;
        logic [LEN_W-1:0]  aad;
        logic [LEN_W-1:0]  msg;
    } job_t;

    function automatic logic [BLK_W-1:0] byte_rev(input logic [BLK_W-1:0] v);
        logic [BLK_W-1:0] r;
        for (int b = 0; b < BYTES; b++) begin
            r[b*8 +: 8] = v[(BYTES-1-b)*8 +: 8];
        end
        return r;
    endfunction

    // One step of multiplication by x in the reflected field.
    function automatic logic [BLK_W-1:0] refl_mulx(input logic [BLK_W-1:0] v);
        return (v >> 1) ^ (v[0] ? REFL_FB : '0);
    endfunction

    // Key as seen by the shared multiplier for each field.
    function automatic logic [BLK_W-1:0] prep_key(input field_e f,
                                                  input logic [BLK_W-1:0] k);
        return (f == FLD_LE) ? refl_mulx(byte_rev(k)) : k;
    endfunction

endpackage

// File: rtl/ghpv_mul_serial.sv
module ghpv_mul_serial
    import ghpv_pkg::*;
#(
    parameter int W = BLK_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_h,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] prod
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    logic [W-1:0]  x_q, v_q, z_q;
    logic [W-1:0]  z_nx, v_nx;
    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_comb begin
        z_nx = z_q ^ (x_q[W-1] ? v_q : '0);
        v_nx = (v_q >> 1) ^ (v_q[0] ? REFL_FB[BLK_W-1 -: W] : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            v_q    <= '0;
            z_q    <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (load) begin
            x_q    <= op_x;
            v_q    <= op_h;
            z_q    <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            x_q   <= x_q << 1;
            v_q   <= v_nx;
            z_q   <= z_nx;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_STEP) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
    assign fin  = busy_q && (cnt_q == LAST_STEP);
    assign prod = z_nx;

endmodule

// File: rtl/ghpv_fmt.sv
module ghpv_fmt
    import ghpv_pkg::*;
(
    input  field_e             fld,
    input  logic [BLK_W-1:0]   blk_in,
    input  logic [LEN_W-1:0]   aad,
    input  logic [LEN_W-1:0]   msg,
    input  logic [BLK_W-1:0]   acc_in,
    output logic [BLK_W-1:0]   blk_map,
    output logic [BLK_W-1:0]   len_map,
    output logic [BLK_W-1:0]   acc_map
);
    logic [BLK_W-1:0] blk_rev, acc_rev;

    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_rev
            assign blk_rev[b*8 +: 8] = blk_in[(BYTES-1-b)*8 +: 8];
            assign acc_rev[b*8 +: 8] = acc_in[(BYTES-1-b)*8 +: 8];
        end
    endgenerate

    // Little-endian lengths, once the whole block is byte reversed, become
    // the big-endian lengths in swapped halves.
    always_comb begin
        if (fld == FLD_LE) begin
            blk_map = blk_rev;
            len_map = {msg, aad};
            acc_map = acc_rev;
        end else begin
            blk_map = blk_in;
            len_map = {aad, msg};
            acc_map = acc_in;
        end
    end

endmodule

// File: rtl/ghpv_hash.sv
module ghpv_hash
    import ghpv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               mode,
    input  logic [BLK_W-1:0]   key,
    input  logic [LEN_W-1:0]   aad_bits,
    input  logic [LEN_W-1:0]   msg_bits,
    input  logic               blk_valid,
    input  logic [BLK_W-1:0]   blk_data,
    input  logic               blk_last,
    output logic               blk_ready,
    output logic [BLK_W-1:0]   hash,
    output logic               done
);
    state_e            state_q;
    job_t              job_q;
    logic [BLK_W-1:0]  hkey_q, y_q, hash_q;
    logic              last_q, len_q, done_q;

    field_e            fld_in;
    logic [BLK_W-1:0]  hkey_in;
    logic              empty_job;

    logic              mul_load, mul_busy, mul_fin;
    logic [BLK_W-1:0]  mul_op, mul_h, mul_prod;
    logic [BLK_W-1:0]  blk_map, len_map, res_map;

    assign fld_in    = field_e'(mode);
    assign hkey_in   = prep_key(fld_in, key);
    assign empty_job = (aad_bits == '0) && (msg_bits == '0);

    ghpv_fmt u_fmt (
        .fld     (job_q.fld),
        .blk_in  (blk_data),
        .aad     (job_q.aad),
        .msg     (job_q.msg),
        .acc_in  (mul_prod),
        .blk_map (blk_map),
        .len_map (len_map),
        .acc_map (res_map)
    );

    always_comb begin
        mul_load = 1'b0;
        mul_op   = '0;
        mul_h    = hkey_q;
        unique case (state_q)
            ST_IDLE: begin
                mul_h = hkey_in;
                if (start && empty_job) begin
                    mul_load = 1'b1;
                end
            end
            ST_TAKE: begin
                if (blk_valid) begin
                    mul_load = 1'b1;
                    mul_op   = y_q ^ blk_map;
                end
            end
            ST_MUL: begin
                if (mul_fin && last_q && !len_q) begin
                    mul_load = 1'b1;
                    mul_op   = mul_prod ^ len_map;
                end
            end
            default: ;
        endcase
    end

    ghpv_mul_serial #(.W(BLK_W)) u_mul (
        .clk  (clk),
        .rst  (rst),
        .load (mul_load),
        .op_x (mul_op),
        .op_h (mul_h),
        .busy (mul_busy),
        .fin  (mul_fin),
        .prod (mul_prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            job_q   <= '0;
            hkey_q  <= '0;
            y_q     <= '0;
            hash_q  <= '0;
            last_q  <= 1'b0;
            len_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        job_q.fld <= fld_in;
                        job_q.aad <= aad_bits;
                        job_q.msg <= msg_bits;
                        hkey_q    <= hkey_in;
                        y_q       <= '0;
                        last_q    <= 1'b0;
                        len_q     <= empty_job;
                        state_q   <= empty_job ? ST_MUL : ST_TAKE;
                    end
                end
                ST_TAKE: begin
                    if (blk_valid) begin
                        last_q  <= blk_last;
                        state_q <= ST_MUL;
                    end
                end
                ST_MUL: begin
                    if (mul_fin) begin
                        y_q <= mul_prod;
                        if (len_q) begin
                            hash_q  <= res_map;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (last_q) begin
                            len_q <= 1'b1;
                        end else begin
                            state_q <= ST_TAKE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign blk_ready = (state_q == ST_TAKE);
    assign hash      = hash_q;
    assign done      = done_q;

endmodule

// File: rtl/ghpv_hash_chk.sv
module ghpv_hash_chk
    import ghpv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             blk_valid,
    input logic             blk_ready,
    input logic [BLK_W-1:0] hash,
    input logic             done
);
    localparam int WIN = BLK_W;
    localparam int WW  = $clog2(WIN + 1);

    logic [WW-1:0] win_q;
    logic          rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            win_q <= '0;
        end else if (blk_valid && blk_ready) begin
            win_q <= WW'(WIN);
        end else if (win_q != '0) begin
            win_q <= win_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_q && !rst) begin
            AST_RESET_QUIET: assert (!blk_ready && !done && hash == '0); // R1
        end
    end

    AST_READY_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (win_q != '0) |-> !blk_ready); // R4

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (blk_valid && blk_ready) |=> !blk_ready); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !(done && blk_ready)); // R5

    AST_HASH_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |=> (done || $stable(hash))); // R10

endmodule

bind ghpv_hash ghpv_hash_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .blk_valid (blk_valid),
    .blk_ready (blk_ready),
    .hash      (hash),
    .done      (done)
);

// File: tb/ghpv_hash_tb.sv
module ghpv_hash_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;
    localparam logic [127:0] FB_BE = {8'hE1, 120'h0};
    localparam logic [127:0] FB_LE = 128'hC200_0000_0000_0000_0000_0000_0000_0001;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic [127:0] key = '0;
    logic [63:0]  aad_bits = '0;
    logic [63:0]  msg_bits = '0;
    logic         blk_valid = 1'b0;
    logic [127:0] blk_data = '0;
    logic         blk_last = 1'b0;
    logic         blk_ready;
    logic [127:0] hash;
    logic         done;

    int total = 0;
    int bad   = 0;
    logic [127:0] blks [0:7];
    logic [127:0] rng = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

    always #(CLK_PERIOD/2) clk = ~clk;

    ghpv_hash u_dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .key(key),
        .aad_bits(aad_bits), .msg_bits(msg_bits), .blk_valid(blk_valid),
        .blk_data(blk_data), .blk_last(blk_last), .blk_ready(blk_ready),
        .hash(hash), .done(done)
    );

    function automatic logic [127:0] brev(input logic [127:0] v);
        logic [127:0] r;
        for (int b = 0; b < 16; b++) r[b*8 +: 8] = v[(15-b)*8 +: 8];
        return r;
    endfunction

    // Reflected-field product, bit 127 of the bus is x^0.
    function automatic logic [127:0] be_mul(input logic [127:0] x, input logic [127:0] y);
        logic [127:0] z = '0;
        logic [127:0] v = y;
        for (int i = 0; i < 128; i++) begin
            if (x[127-i]) z ^= v;
            v = v[0] ? ((v >> 1) ^ FB_BE) : (v >> 1);
        end
        return z;
    endfunction

    // Little-endian field: a*b*x^-128, bit k is x^k.
    function automatic logic [127:0] le_dot(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] acc = '0;
        for (int i = 0; i < 128; i++) begin
            if (b[i]) acc ^= a;
            if (acc[0]) acc = ((acc ^ FB_LE) >> 1) ^ {1'b1, 127'h0};
            else        acc = acc >> 1;
        end
        return acc;
    endfunction

    function automatic logic [127:0] model(input logic m, input logic [127:0] k,
                                           input int n, input logic [63:0] a,
                                           input logic [63:0] g);
        logic [127:0] y = '0;
        if (!m) begin
            for (int i = 0; i < n; i++) y = be_mul(y ^ blks[i], k);
            y = be_mul(y ^ {a, g}, k);
            return y;
        end
        for (int i = 0; i < n; i++) y = le_dot(y ^ brev(blks[i]), brev(k));
        y = le_dot(y ^ {g, a}, brev(k));
        return brev(y);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
    endtask

    // Runs one hash over blks[0..n-1]; poke pulses a stray start mid-run,
    // hold keeps blk_valid high across multiplies.
    task automatic run_hash(input logic m, input logic [127:0] k, input int n,
                            input logic [63:0] a, input logic [63:0] g,
                            input bit poke, input bit hold, input string tag,
                            output logic [127:0] res);
        int cnt;
        logic [127:0] exp_v;
        exp_v = model(m, k, n, a, g);
        @(negedge clk);
        start = 1'b1; mode = m; key = k; aad_bits = a; msg_bits = g;
        @(negedge clk);
        start = 1'b0; key = ~k; mode = ~m; aad_bits = ~a; msg_bits = '0;
        if (n == 0) begin
            cnt = 0;
            while (!done) begin
                if (blk_ready) chk(0, "R6 ready rose", 1, 0);
                cnt++;
                @(negedge clk);
            end
            chk(cnt == 128, "R6 latency", cnt, 128);
        end else begin
            for (int i = 0; i < n; i++) begin
                blk_valid = 1'b1; blk_data = blks[i]; blk_last = (i == n-1);
                while (!blk_ready) @(negedge clk);
                @(negedge clk);
                if (!hold) begin
                    blk_valid = 1'b0; blk_data = ~blks[i];
                end else if (i + 1 < n) begin
                    blk_data = blks[i+1]; blk_last = (i + 1 == n - 1);
                end
                if (poke && i == 0) begin
                    start = 1'b1; mode = ~m; key = ~k; aad_bits = '0; msg_bits = '0;
                    @(negedge clk);
                    start = 1'b0;
                    cnt = 1;
                end else begin
                    cnt = 0;
                end
                if (i < n-1) begin
                    while (!blk_ready) begin cnt++; @(negedge clk); end
                    chk(cnt == 128, {"R4 ready window ", tag}, cnt, 128);
                end else begin
                    blk_valid = 1'b0;
                    while (!done) begin
                        if (blk_ready) chk(0, "R5 ready after last", 1, 0);
                        cnt++;
                        @(negedge clk);
                    end
                    chk(cnt == 256, {"R5 done latency ", tag}, cnt, 256);
                end
            end
        end
        res = hash;
        chk(res == exp_v, tag, res, exp_v);
        @(negedge clk);
        chk(!done, "R5 done single pulse", done, 0);
        chk(hash == res, "R10 hash held", hash, res);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [127:0] r1, r2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!blk_ready && !done && hash == '0, "R1 reset state",
            {blk_ready, done, hash[125:0]}, 0);

        // R6: empty hash in both fields is zero.
        run_hash(1'b0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 0, 64'd0, 64'd0, 0, 0, "R6 empty be", r1);
        chk(r1 == '0, "R6 empty zero", r1, 0);
        run_hash(1'b1, 128'h25629347589242761d31f826ba4b757b, 0, 64'd0, 64'd0, 0, 0, "R6 empty le", r1);
        chk(r1 == '0, "R6 empty zero", r1, 0);

        // R2/R3 walking-one key sweep, one data block per hash.
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 128; b++) begin
                blks[0] = {32'hA5A5_0000 ^ b, 32'h1234_5678 * (b + 1),
                           32'hDEAD_BEEF ^ (b << 8), 32'h0F0F_F0F0 + b};
                run_hash(m[0], 128'h1 << b, 1, 64'd128 + b, 64'd8 * b, 0, 0,
                         m ? "R3 key sweep" : "R2 key sweep", r1);
            end
        end

        // R2/R3 multi-block with pseudo-random data and keys, R9 hold mode.
        for (int t = 0; t < 8; t++) begin
            for (int i = 0; i < 4; i++) begin next_rng(); blks[i] = rng; end
            next_rng();
            run_hash(t[0], rng, 1 + (t % 4), {32'h0, rng[31:0]}, {32'h0, rng[63:32]},
                     0, t[1], t[0] ? "R3 R9 multi" : "R2 R9 multi", r1);
        end

        // R7: back-to-back identical hashes.
        for (int i = 0; i < 3; i++) begin next_rng(); blks[i] = rng; end
        run_hash(1'b1, 128'hF00D, 3, 64'd256, 64'd120, 0, 0, "R7 first", r1);
        run_hash(1'b1, 128'hF00D, 3, 64'd256, 64'd120, 0, 0, "R7 second", r2);
        chk(r1 == r2, "R7 restart", r2, r1);

        // R8: stray start mid-hash ignored.
        run_hash(1'b0, 128'hCAFE_0000_0000_1234, 3, 64'd384, 64'd0, 1, 0, "R8 be poke", r1);
        run_hash(1'b1, 128'hCAFE_0000_0000_1234, 3, 64'd0, 64'd384, 1, 1, "R8 le poke", r1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule